// File: doc/BRIEF.md
# Flash Page Prefetch Buffer Controller

This block sits between a 32-bit read port and a flash array whose every read delivers a whole 128-bit page. It keeps four page-sized lines in a fully associative buffer. A read that finds its page in a valid line is answered in the cycle after it is accepted. A read that finds no line starts an array read and holds the port until the page arrives. The returned page is written into the buffer at the same time as the requested bytes go back to the host.

Once a demand access has been served, the controller fetches the next sequential page in the background, as long as that page is not already held. This lets a core without a cache run straight-line code with almost no stalls. Replacement follows least-recently-used order, kept as a per-line age rank. An invalidate input empties the buffer and discards any prefetch that is still in flight. Two configuration inputs turn buffering and prefetching on or off independently.

Top module: `pfb_ctrl`

## Requirements
- R1: The page tag is address bits [ADDR_W-1:4]. Each of the four lines holds one 128-bit page. A read hits when a valid line carries its tag, and reads whose addresses differ only above bit 3 never share a line.
- R2: A read accepted (`rd_req` high while `rd_rdy` is high) that hits raises `rd_vld` with its data in the very next cycle, which is zero wait states.
- R3: Address bits [3:2] pick word k = line bits [32k+31:32k]. The word is shifted right by 8 times address bits [1:0]. It is then masked by `rd_size` (0 keeps 8 bits, 1 keeps 16 bits, 2 keeps all 32 bits), so the result is right-justified and zero-extended. An access must not cross its 32-bit container.
- R4: An accepted read that misses drives `arr_req` with `arr_addr` set to its page and drops `rd_rdy`. With an array latency of L cycles from request to `arr_done`, the response appears L cycles after acceptance, carrying the array data, and the page is stored in a line.
- R5: A fill goes to the lowest-numbered invalid line. When every line is valid, it goes to the least recently used line. A hit or a fill makes its line the most recently used.
- R6: After a demand fill, or after a demand hit taken while no array read is outstanding, the page+1 is fetched (wrapping at the top of the page range) and stored without a host response. This happens only when prefetch and buffering are both enabled and page+1 is not already held.
- R7: A read that misses while a prefetch is outstanding waits for it to finish. If it asks for the page being prefetched, it is served from the returning data with no second array read. Otherwise its own array read follows next.
- R8: `arr_req` and `arr_addr` stay steady from the request until the cycle in which `arr_done` is sampled high.
- R9: `inval` clears every line, so later reads miss. A lookup in the same cycle misses, a fill in the same cycle is dropped, and an outstanding prefetch's data is discarded.
- R10: With `buf_en` low every read goes to the array and waits L cycles. Nothing is stored and nothing is prefetched.
- R11: With `pf_en` low and `buf_en` high, demand pages are still buffered, but no prefetch reads are issued.
- R12: After reset all lines are invalid, `rd_rdy` is high, and `rd_vld` and `arr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_en | input | 1 | Enables storing pages in the lines |
| pf_en | input | 1 | Enables next-page prefetch |
| inval | input | 1 | Clears all lines and cancels prefetch |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_size | input | 2 | 0 byte, 1 halfword, 2 word |
| rd_rdy | output | 1 | Controller can accept a request |
| rd_vld | output | 1 | Read data valid for one cycle |
| rd_data | output | DATA_W | Right-justified read data |
| arr_req | output | 1 | Array read request |
| arr_addr | output | ADDR_W-4 | Page index for the array |
| arr_done | input | 1 | Array page returned this cycle |
| arr_line | input | LINE_W | Page data from the array |

## Verification
The bench fills all four lines, refreshes the oldest one, and then forces two evictions in a row. A design that replaced lines in fill order, or forgot to refresh a line on a hit, would throw out a page that is still in use, and that page would come back with L wait states instead of zero. Two cases target a miss that lands during an outstanding prefetch: one asks for the page being fetched, the other for an unrelated page. A wrong design would issue a duplicate array read, return the stale line, or lose the waiting request, and the array read log or the data would show it. Invalidation in the middle of a prefetch, together with the byte and halfword lanes at every offset, catches a prefetched page that survives the clear and a lane select or shift taken from the wrong address bits.

// File: rtl/pfb_pkg.sv
`timescale 1ns/1ps
package pfb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEM  = 2'd1,
    ST_PF   = 2'd2
  } pfb_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/pfb_lru.sv
`timescale 1ns/1ps
// Age-rank replacement tracker: age 0 is most recent, ENTRIES-1 is the victim.
module pfb_lru #(
  parameter int ENTRIES = 4,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ENTRIES-1:0]    valid,
  input  logic                  touch_a,
  input  logic [IW-1:0]         idx_a,
  input  logic                  touch_b,
  input  logic [IW-1:0]         idx_b,
  output logic [IW-1:0]         victim,
  output logic [ENTRIES*IW-1:0] ages_o
);
  typedef logic [ENTRIES-1:0][IW-1:0] age_t;

  age_t age_q, age_n;

  function automatic age_t bump(input age_t a, input logic [IW-1:0] idx);
    age_t r;
    r = a;
    for (int j = 0; j < ENTRIES; j++) begin
      if (j == int'(idx))      r[j] = '0;
      else if (a[j] < a[idx])  r[j] = a[j] + IW'(1);
    end
    return r;
  endfunction

  // Hit touch first, fill touch last, so a fill ends up most recent.
  always_comb begin
    age_t t;
    t = age_q;
    if (touch_a) t = bump(t, idx_a);
    if (touch_b) t = bump(t, idx_b);
    age_n = t;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < ENTRIES; j++) age_q[j] <= IW'(j);
    end else begin
      age_q <= age_n;
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int j = 0; j < ENTRIES; j++) begin
      if (!found && !valid[j]) begin
        victim = IW'(j);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int j = 0; j < ENTRIES; j++)
        if (age_q[j] == IW'(ENTRIES - 1)) victim = IW'(j);
    end
  end

  assign ages_o = age_q;
endmodule

// File: rtl/pfb_lines.sv
`timescale 1ns/1ps
// Line storage with tags, valid bits and two parallel tag comparators.
module pfb_lines #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 16,
  parameter int LINE_W  = 128,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [LINE_W-1:0]  wr_line,
  input  logic [TAG_W-1:0]   look_tag,
  output logic               look_hit,
  output logic [IW-1:0]      look_idx,
  input  logic [TAG_W-1:0]   probe_tag,
  output logic               probe_hit,
  input  logic [IW-1:0]      rd_idx,
  output logic [LINE_W-1:0]  rd_line,
  output logic [ENTRIES-1:0] valid_o
);
  logic [LINE_W-1:0]  mem   [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] mt_look, mt_probe;
  logic               wr_ok;

  assign wr_ok = wr_en && !clr;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_idx] <= wr_line;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) tag_q[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  valid_q <= '0;
    else if (wr_ok)  valid_q[wr_idx] <= 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign mt_look[g]  = valid_q[g] && (tag_q[g] == look_tag);
    assign mt_probe[g] = valid_q[g] && (tag_q[g] == probe_tag);
  end

  always_comb begin
    look_idx = '0;
    for (int j = 0; j < ENTRIES; j++)
      if (mt_look[j]) look_idx = IW'(j);
  end

  assign look_hit  = |mt_look;
  assign probe_hit = |mt_probe;
  assign rd_line   = mem[rd_idx];
  assign valid_o   = valid_q;
endmodule

// File: rtl/pfb_ctrl.sv
`timescale 1ns/1ps
// Prefetching line buffer between a 32-bit read port and a page-wide flash array.
module pfb_ctrl import pfb_pkg::*; #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int LINE_W  = 128,
  parameter int ENTRIES = 4,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int BSEL_W = $clog2(DATA_W / 8),
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_en,
  input  logic              pf_en,
  input  logic              inval,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  output logic              rd_rdy,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data,
  output logic              arr_req,
  output logic [PAGE_W-1:0] arr_addr,
  input  logic              arr_done,
  input  logic [LINE_W-1:0] arr_line
);
  pfb_state_e state_q, state_n;

  logic [PAGE_W-1:0] req_page, dem_page_q, dem_page_n, pf_page_q, pf_page_n;
  logic [PAGE_W-1:0] arr_addr_q, arr_addr_n, probe_tag, eff_page, fill_tag;
  logic [OFF_W-1:0]  req_off, dem_off_q, dem_off_n, eff_off;
  logic [1:0]        dem_size_q, dem_size_n, eff_size;
  logic              pend_q, pend_n, pf_kill_q, pf_kill_n;
  logic              arr_req_q, arr_req_n, rd_vld_q, rd_vld_n;
  logic [DATA_W-1:0] rd_data_q, rd_data_n;
  logic              look_hit, probe_hit, hit, accept, done, pf_ok, eff_pend, fill_en;
  logic [IW-1:0]     look_idx, victim;
  logic [LINE_W-1:0] rd_line;
  logic [ENTRIES-1:0]    valid_v;
  logic [ENTRIES*IW-1:0] ages_v;

  function automatic logic [DATA_W-1:0] lane(input logic [LINE_W-1:0] ln,
                                             input logic [OFF_W-1:0]  off,
                                             input logic [1:0]        sz);
    logic [DATA_W-1:0] w;
    w = ln[off[OFF_W-1:BSEL_W]*DATA_W +: DATA_W];
    w = w >> {off[BSEL_W-1:0], 3'b000};
    if (sz == SZ_BYTE)      w = w & DATA_W'(8'hFF);
    else if (sz == SZ_HALF) w = w & DATA_W'(16'hFFFF);
    return w;
  endfunction

  assign req_page = rd_addr[ADDR_W-1:OFF_W];
  assign req_off  = rd_addr[OFF_W-1:0];
  assign rd_rdy   = (state_q == ST_IDLE) || (state_q == ST_PF && !pend_q);
  assign accept   = rd_req && rd_rdy;
  assign hit      = look_hit && buf_en && !inval;
  assign done     = arr_done && arr_req_q;
  assign probe_tag = (state_q == ST_IDLE) ? req_page + PAGE_W'(1)
                                          : dem_page_q + PAGE_W'(1);
  assign pf_ok    = pf_en && buf_en && !probe_hit && !inval;

  // A miss that is waiting, or one arriving in this very cycle.
  assign eff_pend = pend_q || (accept && !hit);
  assign eff_page = pend_q ? dem_page_q : req_page;
  assign eff_off  = pend_q ? dem_off_q  : req_off;
  assign eff_size = pend_q ? dem_size_q : rd_size;

  always_comb begin
    state_n    = state_q;
    dem_page_n = dem_page_q;
    dem_off_n  = dem_off_q;
    dem_size_n = dem_size_q;
    pend_n     = pend_q;
    pf_page_n  = pf_page_q;
    pf_kill_n  = pf_kill_q || inval;
    arr_req_n  = arr_req_q;
    arr_addr_n = arr_addr_q;
    rd_vld_n   = 1'b0;
    rd_data_n  = rd_data_q;
    fill_en    = 1'b0;
    fill_tag   = dem_page_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && hit) begin
          rd_vld_n  = 1'b1;
          rd_data_n = lane(rd_line, req_off, rd_size);
          if (pf_ok) begin
            state_n    = ST_PF;
            arr_req_n  = 1'b1;
            arr_addr_n = req_page + PAGE_W'(1);
            pf_page_n  = req_page + PAGE_W'(1);
            pf_kill_n  = 1'b0;
          end
        end else if (accept) begin
          state_n    = ST_DEM;
          arr_req_n  = 1'b1;
          arr_addr_n = req_page;
          dem_page_n = req_page;
          dem_off_n  = req_off;
          dem_size_n = rd_size;
        end
      end
      ST_DEM: begin
        if (done) begin
          rd_vld_n  = 1'b1;
          rd_data_n = lane(arr_line, dem_off_q, dem_size_q);
          fill_en   = buf_en;
          fill_tag  = dem_page_q;
          if (pf_ok) begin
            state_n    = ST_PF;
            arr_addr_n = dem_page_q + PAGE_W'(1);
            pf_page_n  = dem_page_q + PAGE_W'(1);
            pf_kill_n  = 1'b0;
          end else begin
            state_n   = ST_IDLE;
            arr_req_n = 1'b0;
          end
        end
      end
      ST_PF: begin
        if (accept && hit) begin
          rd_vld_n  = 1'b1;
          rd_data_n = lane(rd_line, req_off, rd_size);
        end else if (accept) begin
          pend_n     = 1'b1;
          dem_page_n = req_page;
          dem_off_n  = req_off;
          dem_size_n = rd_size;
        end
        if (done) begin
          fill_en  = buf_en && !pf_kill_q;
          fill_tag = pf_page_q;
          pend_n   = 1'b0;
          if (eff_pend && !pf_kill_q && !inval && eff_page == pf_page_q) begin
            rd_vld_n  = 1'b1;
            rd_data_n = lane(arr_line, eff_off, eff_size);
            state_n   = ST_IDLE;
            arr_req_n = 1'b0;
          end else if (eff_pend) begin
            state_n    = ST_DEM;
            arr_addr_n = eff_page;
            dem_page_n = eff_page;
            dem_off_n  = eff_off;
            dem_size_n = eff_size;
          end else begin
            state_n   = ST_IDLE;
            arr_req_n = 1'b0;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      dem_page_q <= '0;
      dem_off_q  <= '0;
      dem_size_q <= '0;
      pend_q     <= 1'b0;
      pf_page_q  <= '0;
      pf_kill_q  <= 1'b0;
      arr_req_q  <= 1'b0;
      arr_addr_q <= '0;
      rd_vld_q   <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      state_q    <= state_n;
      dem_page_q <= dem_page_n;
      dem_off_q  <= dem_off_n;
      dem_size_q <= dem_size_n;
      pend_q     <= pend_n;
      pf_page_q  <= pf_page_n;
      pf_kill_q  <= pf_kill_n;
      arr_req_q  <= arr_req_n;
      arr_addr_q <= arr_addr_n;
      rd_vld_q   <= rd_vld_n;
      rd_data_q  <= rd_data_n;
    end
  end

  pfb_lines #(.ENTRIES(ENTRIES), .TAG_W(PAGE_W), .LINE_W(LINE_W)) u_lines (
    .clk       (clk),
    .rst       (rst),
    .clr       (inval),
    .wr_en     (fill_en),
    .wr_idx    (victim),
    .wr_tag    (fill_tag),
    .wr_line   (arr_line),
    .look_tag  (req_page),
    .look_hit  (look_hit),
    .look_idx  (look_idx),
    .probe_tag (probe_tag),
    .probe_hit (probe_hit),
    .rd_idx    (look_idx),
    .rd_line   (rd_line),
    .valid_o   (valid_v)
  );

  pfb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk     (clk),
    .rst     (rst),
    .valid   (valid_v),
    .touch_a (accept && hit),
    .idx_a   (look_idx),
    .touch_b (fill_en && !inval),
    .idx_b   (victim),
    .victim  (victim),
    .ages_o  (ages_v)
  );

  assign rd_vld   = rd_vld_q;
  assign rd_data  = rd_data_q;
  assign arr_req  = arr_req_q;
  assign arr_addr = arr_addr_q;
endmodule

// File: rtl/pfb_chk.sv
`timescale 1ns/1ps
module pfb_chk import pfb_pkg::*; #(
  parameter int ENTRIES = 4,
  parameter int PAGE_W  = 16,
  localparam int IW = $clog2(ENTRIES)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  accept,
  input logic                  hit,
  input logic                  rd_vld,
  input logic                  rd_rdy,
  input logic                  arr_req,
  input logic                  arr_done,
  input logic                  inval,
  input logic [PAGE_W-1:0]     arr_addr,
  input logic [ENTRIES-1:0]    valid,
  input logic [ENTRIES*IW-1:0] ages,
  input pfb_state_e            state
);
  logic ranks_distinct;

  always_comb begin
    ranks_distinct = 1'b1;
    for (int a = 0; a < ENTRIES; a++)
      for (int b = a + 1; b < ENTRIES; b++)
        if (ages[a*IW +: IW] == ages[b*IW +: IW]) ranks_distinct = 1'b0;
  end

  p_hit_zero_wait_r2: assert property (@(posedge clk) disable iff (rst)
    accept && hit |=> rd_vld);

  p_miss_stall_r4: assert property (@(posedge clk) disable iff (rst)
    accept && !hit && state == ST_IDLE |=> !rd_rdy && arr_req);

  p_arr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    arr_req && !arr_done |=> arr_req && $stable(arr_addr));

  p_inval_clear_r9: assert property (@(posedge clk) disable iff (rst)
    inval |=> valid == '0);

  always @(posedge clk) begin
    if (!rst) p_rank_perm_r5: assert (ranks_distinct);
  end
endmodule

bind pfb_ctrl pfb_chk #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .accept   (accept),
  .hit      (hit),
  .rd_vld   (rd_vld),
  .rd_rdy   (rd_rdy),
  .arr_req  (arr_req),
  .arr_done (arr_done),
  .inval    (inval),
  .arr_addr (arr_addr),
  .valid    (valid_v),
  .ages     (ages_v),
  .state    (state_q)
);

// File: tb/tb_pfb_ctrl.sv
`timescale 1ns/1ps
module tb_pfb_ctrl;
  localparam int ADDR_W = 20;
  localparam int PAGE_W = ADDR_W - 4;

  logic clk = 0, rst = 1;
  logic buf_en = 1, pf_en = 0, inval = 0;
  logic rd_req = 0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [1:0] rd_size = 2'd2;
  logic rd_rdy, rd_vld, arr_req, arr_done = 0;
  logic [31:0] rd_data;
  logic [PAGE_W-1:0] arr_addr;
  logic [127:0] arr_line = '0;

  int n_chk = 0, n_bad = 0, lat = 2, n_reads = 0, hold_err = 0;
  int alog [0:255];

  always #2.5 clk = ~clk;

  pfb_ctrl dut (.clk(clk), .rst(rst), .buf_en(buf_en), .pf_en(pf_en), .inval(inval),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_rdy(rd_rdy),
    .rd_vld(rd_vld), .rd_data(rd_data), .arr_req(arr_req), .arr_addr(arr_addr),
    .arr_done(arr_done), .arr_line(arr_line));

  function automatic logic [31:0] wgen(input int page, input int k);
    return {8'(page), 8'(page >> 8) ^ 8'h5A, 8'(8'h30 + k), 8'(8'hC0 ^ (k * 17) ^ page)};
  endfunction

  function automatic logic [31:0] expv(input int addr, input logic [1:0] sz);
    logic [31:0] w;
    w = wgen(addr >> 4, (addr >> 2) & 3) >> (8 * (addr & 3));
    if (sz == 2'd0) w = w & 32'hFF;
    else if (sz == 2'd1) w = w & 32'hFFFF;
    return w;
  endfunction

  // Array model: sees a request, waits lat cycles, returns the page.
  initial begin
    forever begin
      @(negedge clk);
      arr_done = 0;
      if (arr_req) begin
        int pg;
        pg = int'(arr_addr);
        if (n_reads < 256) alog[n_reads] = pg;
        n_reads++;
        repeat (lat - 1) begin
          @(negedge clk);
          if (!arr_req || int'(arr_addr) != pg) hold_err++;
        end
        for (int k = 0; k < 4; k++) arr_line[32*k +: 32] = wgen(pg, k);
        arr_done = 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input int addr, input logic [1:0] sz, output logic [31:0] d, output int waits);
    rd_addr = ADDR_W'(addr);
    rd_size = sz;
    rd_req = 1;
    while (!rd_rdy) @(negedge clk);
    @(negedge clk);
    rd_req = 0;
    waits = 0;
    while (!rd_vld) begin
      waits++;
      @(negedge clk);
    end
    d = rd_data;
  endtask

  task automatic settle();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      if (!arr_req && !rd_vld) q++; else q = 0;
    end
  endtask

  task automatic pulse_inval();
    inval = 1;
    @(negedge clk);
    inval = 0;
    settle();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset();
    chk("R12 rd_rdy", 32'(rd_rdy), 1);
    chk("R12 rd_vld", 32'(rd_vld), 0);
    chk("R12 arr_req", 32'(arr_req), 0);
  endtask

  task automatic t_basic();
    logic [31:0] d; int w, n0;
    pf_en = 0; lat = 2; pulse_inval(); n0 = n_reads;
    rd(32'h1000, 2'd2, d, w);
    chk("R4 miss waits", 32'(w), 2);
    chk("R4 miss data", d, expv(32'h1000, 2'd2));
    rd(32'h1008, 2'd2, d, w);
    chk("R2 hit waits", 32'(w), 0);
    chk("R1 hit data", d, expv(32'h1008, 2'd2));
    rd(32'h11008, 2'd2, d, w);
    chk("R1 upper tag bits miss", 32'(w), 2);
    chk("R1 upper tag data", d, expv(32'h11008, 2'd2));
    settle();
    chk("R11 no prefetch reads", 32'(n_reads - n0), 2);
  endtask

  task automatic t_lanes();
    logic [31:0] d; int w;
    for (int b = 0; b < 4; b++) begin
      rd(32'h1004 + b, 2'd0, d, w);
      chk("R3 byte lane", d, expv(32'h1004 + b, 2'd0));
    end
    for (int h = 0; h < 3; h++) begin
      rd(32'h100C + h, 2'd1, d, w);
      chk("R3 half lane", d, expv(32'h100C + h, 2'd1));
    end
    for (int k = 0; k < 4; k++) begin
      rd(32'h1000 + 4 * k, 2'd2, d, w);
      chk("R3 word select", d, expv(32'h1000 + 4 * k, 2'd2));
    end
  endtask

  task automatic t_prefetch();
    logic [31:0] d; int w, n0;
    pf_en = 1; lat = 2; pulse_inval(); n0 = n_reads;
    rd(32'h2000, 2'd2, d, w);
    settle();
    chk("R6 prefetch issued", 32'(n_reads - n0), 2);
    chk("R6 prefetch page", 32'(alog[n0 + 1]), 32'h201);
    rd(32'h2014, 2'd2, d, w);
    chk("R6 prefetched hit waits", 32'(w), 0);
    chk("R6 prefetched data", d, expv(32'h2014, 2'd2));
    settle();
    chk("R6 prefetch after hit", 32'(alog[n0 + 2]), 32'h202);
  endtask

  task automatic t_during_pf();
    logic [31:0] d; int w, n0;
    pf_en = 1; lat = 6; pulse_inval(); n0 = n_reads;
    rd(32'h5000, 2'd2, d, w);
    rd(32'h5018, 2'd2, d, w);
    chk("R7 same page data", d, expv(32'h5018, 2'd2));
    chk("R7 served early", 32'(w < 6), 1);
    settle();
    chk("R7 no second read", 32'(n_reads - n0), 2);
    n0 = n_reads;
    rd(32'h6000, 2'd2, d, w);
    rd(32'h7004, 2'd1, d, w);
    chk("R7 other page data", d, expv(32'h7004, 2'd1));
    settle();
    chk("R7 read order a", 32'(alog[n0 + 1]), 32'h601);
    chk("R7 read order b", 32'(alog[n0 + 2]), 32'h700);
  endtask

  task automatic t_lru();
    logic [31:0] d; int w;
    pf_en = 0; lat = 2; pulse_inval();
    for (int p = 0; p < 4; p++) rd(32'h4000 + 16 * p, 2'd2, d, w);
    rd(32'h4000, 2'd2, d, w);
    chk("R5 refresh hit", 32'(w), 0);
    rd(32'h4040, 2'd2, d, w);
    rd(32'h4000, 2'd2, d, w);
    chk("R5 kept recent line", 32'(w), 0);
    rd(32'h4020, 2'd2, d, w);
    rd(32'h4030, 2'd2, d, w);
    rd(32'h4010, 2'd2, d, w);
    chk("R5 oldest evicted", 32'(w), 2);
    chk("R5 refill data", d, expv(32'h4010, 2'd2));
    rd(32'h4040, 2'd2, d, w);
    chk("R5 second eviction", 32'(w), 2);
  endtask

  task automatic t_inval();
    logic [31:0] d; int w;
    pf_en = 0; lat = 2; pulse_inval();
    rd(32'h8000, 2'd2, d, w);
    rd(32'h8004, 2'd2, d, w);
    chk("R9 hit before clear", 32'(w), 0);
    pulse_inval();
    rd(32'h8004, 2'd2, d, w);
    chk("R9 miss after clear", 32'(w), 2);
    pf_en = 1; lat = 6; pulse_inval();
    rd(32'h9000, 2'd2, d, w);
    inval = 1;
    @(negedge clk);
    inval = 0;
    settle();
    rd(32'h9010, 2'd2, d, w);
    chk("R9 cancelled prefetch misses", 32'(w), 6);
    chk("R9 data after cancel", d, expv(32'h9010, 2'd2));
  endtask

  task automatic t_nobuf();
    logic [31:0] d; int w, n0;
    buf_en = 0; pf_en = 1; lat = 2; settle(); n0 = n_reads;
    rd(32'hA000, 2'd2, d, w);
    rd(32'hA004, 2'd2, d, w);
    chk("R10 repeat still waits", 32'(w), 2);
    chk("R10 data", d, expv(32'hA004, 2'd2));
    settle();
    chk("R10 reads", 32'(n_reads - n0), 2);
    buf_en = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_lanes();
    t_prefetch();
    t_during_pf();
    t_lru();
    t_inval();
    t_nobuf();
    chk("R8 array request held", 32'(hold_err), 0);
    report();
  end
endmodule